// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 management-interface master that sits behind a small word-addressed register bank. Software first loads a target word (PHY address, PHY register number and read/write choice) and, for writes, a 16-bit data word. It then writes the control word with the interface-enable bit and the go bit both set. The block generates the management clock from the system clock and shifts a complete 64-bit management frame onto the data pin. For a read it releases the pin so the PHY can answer, and it collects the returned 16 bits into a read-data register.

The go bit reads back as 1 while the frame runs and drops to 0 when the frame ends, so software polls it to find completion. The enable bit gates the whole interface: with it clear, a go request produces no activity. The management clock stays low and the data pin stays released whenever no frame is in progress.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A control write (word index 3) with go (bit 0) set and enable (bit 1) clear starts nothing: the go bit reads 0, `mdc` stays low and no clock edge appears on `mdc`.
- R3: After a control write with both bits set, the go bit reads 1 for exactly 128*DIV_HALF system clock cycles and then reads 0.
- R4: A write frame (target word bit 16 = 0) shifts out, MSB first on successive `mdc` rising edges: 32 ones, 01, 01, PHY address (target bits 12:8), register number (target bits 4:0), 10, then the write-data word (index 1, bits 15:0).
- R5: A read frame (target bit 16 = 1) sends the same header with opcode 10. From the first turnaround bit to the end of the frame, `mdio_oe` is low, so the PHY never contends with the master.
- R6: During a read frame the 16 data bits are sampled on `mdc` rising edges, MSB first. They appear in the read-data register (index 2, bits 15:0) only when the go bit clears, and the old value is held while the frame runs.
- R7: `mdc` is low for DIV_HALF system clocks and high for DIV_HALF system clocks in each period. When no frame is active, `mdc` is low and `mdio_oe` is low.
- R8: `mdio_o` and `mdio_oe` change only at an `mdc` falling edge or at frame start, and never while `mdc` is high.
- R9: While a frame runs, control writes are ignored: the enable bit is kept and a cleared go bit does not abort the frame. Writes to the target and write-data words are stored and read back, but they do not change the frame in flight.
- R10: A write frame leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Word index: 0 target, 1 write data, 2 read data, 3 control |
| csr_wdata | input | CSR_DW | Register write data |
| csr_rdata | output | CSR_DW | Register read data, combinational on `csr_addr` |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data pin input from the pad |
| mdio_o | output | 1 | Data pin value driven by the master |
| mdio_oe | output | 1 | Data pin drive enable |

## Verification
The bench sweeps every PHY address and every register number in both directions, and checks each full frame bit by bit as a PHY model sees it. A wrong opcode, a field in the wrong place or a missing preamble bit each shows up as a frame miscompare. A master that keeps driving through the turnaround is caught by the contention monitor. A master that updates read data early, or lets a write frame overwrite it, is caught by the mid-frame and after-frame read-data checks. Separate scenarios issue a go request with the interface disabled, disturb every register in the middle of a frame, and measure both `mdc` phases. These catch a block that ignores the enable bit, aborts a frame or picks up new fields partway through, or produces an uneven clock.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants and types for the MDIO management master.
// Assumes clause 22 framing only; field widths are fixed by the frame format.
package mdio_mgmt_pkg;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = PRE_BITS + 4 + PHY_AW + REG_AW;
    localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);

    // register word indices
    localparam int IDX_TARGET = 0;
    localparam int IDX_WDATA  = 1;
    localparam int IDX_RDATA  = 2;
    localparam int IDX_CTRL   = 3;

    // bit positions inside the target and control words
    localparam int TGT_PHY_LSB = 8;
    localparam int TGT_OP_BIT  = 16;
    localparam int CTRL_GO_BIT = 0;
    localparam int CTRL_EN_BIT = 1;

    typedef struct packed {
        logic              rd;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regn;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: management clock generator.
// Produces mdc from clk while run is high, with DIV_HALF clk cycles per
// phase, and gives one-cycle strobes in the cycle before each mdc edge.
// Assumes run drops in the same cycle as the last falling strobe, so mdc
// always rests low.
module mdio_mdc_gen #(
    parameter int DIV_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap = run && (cnt_q == CNT_LAST);

    // phase counter: counts clk cycles within one mdc half period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // clock level: toggles at the end of each half period, rests low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
        end else if (!run) begin
            mdc_q <= 1'b0;
        end else if (wrap) begin
            mdc_q <= ~mdc_q;
        end
    end

    assign mdc      = mdc_q;
    assign rise_stb = wrap && !mdc_q;
    assign fall_stb = wrap && mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: management frame sequencer.
// Loads a 64-bit frame image on start and shifts one bit per mdc falling
// strobe. For reads it releases the pin from the turnaround onwards and
// samples data on rising strobes. Assumes start is only honoured when idle.
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(HDR_BITS);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(HDR_BITS + 2);

    logic                  busy_q;
    logic                  rd_q;
    logic [IDX_W-1:0]      idx_q;
    logic [IDX_W-1:0]      nxt_idx;
    logic [FRAME_BITS-1:0] frame_d;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  out_q;
    logic                  oe_q;
    logic [DATA_W-1:0]     cap_q;
    logic [DATA_W-1:0]     rdata_q;
    logic                  launch;
    logic                  last;

    assign launch  = start && !busy_q;
    assign last    = (idx_q == IDX_LAST);
    assign nxt_idx = idx_q + 1'b1;

    // frame image: preamble, start, opcode, addresses, turnaround, data
    always_comb begin
        frame_d = {{PRE_BITS{1'b1}}, 2'b01,
                   (cmd.rd ? 2'b10 : 2'b01),
                   cmd.phy, cmd.regn,
                   (cmd.rd ? 2'b11 : 2'b10),
                   (cmd.rd ? {DATA_W{1'b1}} : wr_data)};
    end

    // frame control: busy flag, bit index and direction of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            rd_q   <= 1'b0;
        end else if (launch) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            rd_q   <= cmd.rd;
        end else if (busy_q && fall_stb) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= nxt_idx;
            end
        end
    end

    // pin driver: presents the next frame bit after each falling strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            out_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else if (launch) begin
            shreg_q <= frame_d;
            out_q   <= frame_d[FRAME_BITS-1];
            oe_q    <= 1'b1;
        end else if (busy_q && fall_stb) begin
            if (last) begin
                out_q <= 1'b0;
                oe_q  <= 1'b0;
            end else begin
                shreg_q <= shreg_q << 1;
                out_q   <= shreg_q[FRAME_BITS-2];
                oe_q    <= !rd_q || (nxt_idx < IDX_TA);
            end
        end
    end

    // read capture: shifts in data bits, publishes them at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (launch) begin
                cap_q <= '0;
            end else if (busy_q && rise_stb && rd_q && (idx_q >= IDX_DATA)) begin
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            end
            if (busy_q && fall_stb && last && rd_q) begin
                rdata_q <= cap_q;
            end
        end
    end

    assign busy    = busy_q;
    assign mdio_o  = out_q;
    assign mdio_oe = oe_q;
    assign rd_data = rdata_q;

    // R5: master is off the pin from the turnaround to the end of a read
    p_release_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rd_q && (idx_q >= IDX_TA)) |-> !oe_q);

    // R6: read data register holds its value while a frame is in flight
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(rdata_q));

    // R7: pin released whenever no frame is active
    p_idle_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !oe_q);

    // R3: bit index never passes the end of the frame
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q <= IDX_LAST));
endmodule

// File: rtl/mdio_csr_regs.sv
// Module: register front end for the management master.
// Holds the target and write-data words and the enable bit, returns
// combinational read data, and issues a start pulse on an accepted go.
// Assumes CSR_DW is at least 17 so every field fits in one word.
module mdio_csr_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int CSR_AW = 2,
    parameter int CSR_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output mdio_cmd_t         cmd,
    output logic [DATA_W-1:0] wr_data,
    output logic              start
);
    localparam logic [CSR_AW-1:0] A_TARGET = CSR_AW'(IDX_TARGET);
    localparam logic [CSR_AW-1:0] A_WDATA  = CSR_AW'(IDX_WDATA);
    localparam logic [CSR_AW-1:0] A_RDATA  = CSR_AW'(IDX_RDATA);
    localparam logic [CSR_AW-1:0] A_CTRL   = CSR_AW'(IDX_CTRL);

    mdio_cmd_t         cmd_q;
    logic [DATA_W-1:0] wr_q;
    logic              en_q;
    logic              ctrl_wr;
    logic              unused_wbits;

    assign ctrl_wr      = csr_we && (csr_addr == A_CTRL) && !busy;
    assign start        = ctrl_wr && csr_wdata[CTRL_EN_BIT] && csr_wdata[CTRL_GO_BIT];
    assign unused_wbits = ^csr_wdata;

    // target word: register number, PHY address and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (csr_we && (csr_addr == A_TARGET)) begin
            cmd_q.regn <= csr_wdata[REG_AW-1:0];
            cmd_q.phy  <= csr_wdata[TGT_PHY_LSB +: PHY_AW];
            cmd_q.rd   <= csr_wdata[TGT_OP_BIT];
        end
    end

    // write-data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else if (csr_we && (csr_addr == A_WDATA)) begin
            wr_q <= csr_wdata[DATA_W-1:0];
        end
    end

    // interface enable, only writable while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q <= csr_wdata[CTRL_EN_BIT];
        end
    end

    // read mux over the four words
    always_comb begin
        csr_rdata = '0;
        if (csr_addr == A_TARGET) begin
            csr_rdata[REG_AW-1:0]               = cmd_q.regn;
            csr_rdata[TGT_PHY_LSB +: PHY_AW]    = cmd_q.phy;
            csr_rdata[TGT_OP_BIT]               = cmd_q.rd;
        end else if (csr_addr == A_WDATA) begin
            csr_rdata[DATA_W-1:0] = wr_q;
        end else if (csr_addr == A_RDATA) begin
            csr_rdata[DATA_W-1:0] = rd_data;
        end else if (csr_addr == A_CTRL) begin
            csr_rdata[CTRL_GO_BIT] = busy;
            csr_rdata[CTRL_EN_BIT] = en_q;
        end
    end

    assign cmd     = cmd_q;
    assign wr_data = wr_q;

    // R2: a frame only begins with the interface enabled
    p_go_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> en_q);

    // R9: enable bit is frozen while a frame runs
    p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(en_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: MDIO management master top.
// Joins the register front end, the mdc generator and the frame
// sequencer. The pad tristate is built outside from mdio_o and mdio_oe.
// Assumes DIV_HALF is chosen so clk / (2*DIV_HALF) is within the PHY limit.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 10,
    parameter int CSR_AW   = 2,
    parameter int CSR_DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              start;
    logic              busy;
    logic              rise_stb;
    logic              fall_stb;

    mdio_csr_regs #(
        .CSR_AW (CSR_AW),
        .CSR_DW (CSR_DW)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .busy      (busy),
        .rd_data   (rd_data),
        .cmd       (cmd),
        .wr_data   (wr_data),
        .start     (start)
    );

    mdio_mdc_gen #(
        .DIV_HALF (DIV_HALF)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .wr_data  (wr_data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    // R7: clock rests low outside a frame
    p_mdc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R8: pin value and enable never move while mdc is high
    p_pin_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
// Bench: sweeps PHY addresses and register numbers in both directions
// against a PHY responder, checking frames, timing and registers.
module mdio_mgmt_master_tb_top;
    localparam int H  = 2;
    localparam int AW = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] csr_rdata;
    logic          mdc;
    logic          mdio_o;
    logic          mdio_oe;
    logic          mdio_line;

    int vectors = 0;
    int fails = 0;
    int contention = 0;
    logic [15:0] exp_rdata = 16'h0;

    // PHY responder state
    logic [63:0] cap = '0;
    int          k = 0;
    bit          rd_flag = 1'b0;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic [15:0] phy_rsp = 16'h0;

    always #10 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_mgmt_master #(.DIV_HALF(H), .CSR_AW(AW), .CSR_DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_line),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // responder: records the line on each rising mdc edge
    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_line};
        k = k + 1;
        if (k == 36) rd_flag = (cap[1:0] == 2'b10);
    end

    // responder: answers read frames after each falling mdc edge
    always @(negedge mdc) begin
        if (k >= 64) begin
            k = 0;
            phy_en = 1'b0;
        end else if (rd_flag && k >= 47) begin
            phy_en = 1'b1;
            phy_val = (k == 47) ? 1'b0 : phy_rsp[63-k];
        end
    end

    // contention monitor
    always @(negedge clk) begin
        if (rst_n && mdio_oe && phy_en) contention = contention + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors = vectors + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    function automatic logic [31:0] tgt_word(input bit rd, input logic [4:0] phy, input logic [4:0] rg);
        return {15'b0, rd, 3'b0, phy, 3'b0, rg};
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    endfunction

    task automatic run_xfer(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d, input bit disturb);
        int n;
        logic [DW-1:0] rv;
        logic [31:0] alt_tgt;
        alt_tgt = tgt_word(!rd, ~phy, ~rg);
        csr_write(2'd0, tgt_word(rd, phy, rg));
        csr_write(2'd1, {16'h0, d});
        phy_rsp = d;
        csr_write(2'd3, 32'h3);
        csr_addr = 2'd3;
        n = 0;
        while (n < 3000) begin
            if (disturb && n >= 50 && n <= 53) begin
                case (n)
                    50: begin csr_we = 1'b1; csr_addr = 2'd0; csr_wdata = alt_tgt; end
                    51: begin csr_addr = 2'd1; csr_wdata = {16'h0, ~d}; end
                    52: begin csr_addr = 2'd3; csr_wdata = 32'h0; end
                    default: begin csr_we = 1'b0; csr_addr = 2'd3; end
                endcase
            end else begin
                #1;
                if (!csr_rdata[0]) break;
                if (n == 100) begin
                    csr_read(2'd2, rv);
                    chk(rv[15:0] == exp_rdata, "R6 mid-frame hold", rv, exp_rdata);
                    csr_addr = 2'd3;
                end
            end
            n = n + 1;
            @(negedge clk);
        end
        chk(n == 128 * H, "R3 busy length", n, 128 * H);
        chk(cap == exp_frame(rd, phy, rg, d), rd ? "R5 read frame" : "R4 write frame",
            cap, exp_frame(rd, phy, rg, d));
        if (rd) exp_rdata = d;
        csr_read(2'd2, rv);
        chk(rv == {16'h0, exp_rdata}, rd ? "R6 read data" : "R10 read data kept", rv, exp_rdata);
        chk(!mdc && !mdio_oe, "R7 idle pins", {mdc, mdio_oe}, 2'b00);
        if (disturb) begin
            csr_read(2'd0, rv);
            chk(rv == alt_tgt, "R9 target stored", rv, alt_tgt);
            csr_read(2'd1, rv);
            chk(rv == {16'h0, ~d}, "R9 wdata stored", rv, {16'h0, ~d});
            csr_read(2'd3, rv);
            chk(rv == 32'h2, "R9 enable kept", rv, 32'h2);
        end
    endtask

    task automatic run_phase();
        int lo, hi, lo2, n;
        csr_write(2'd0, tgt_word(1'b0, 5'd9, 5'd4));
        csr_write(2'd1, 32'h1234);
        csr_write(2'd3, 32'h3);
        lo = 0; hi = 0; lo2 = 0;
        while (!mdc && lo < 100) begin lo = lo + 1; @(negedge clk); end
        while (mdc && hi < 100) begin hi = hi + 1; @(negedge clk); end
        while (!mdc && lo2 < 100) begin lo2 = lo2 + 1; @(negedge clk); end
        chk(lo == H, "R7 first low phase", lo, H);
        chk(hi == H, "R7 high phase", hi, H);
        chk(lo2 == H, "R7 low phase", lo2, H);
        csr_addr = 2'd3;
        n = 0;
        while (n < 3000) begin
            #1;
            if (!csr_rdata[0]) break;
            n = n + 1;
            @(negedge clk);
        end
        chk(cap == exp_frame(1'b0, 5'd9, 5'd4, 16'h1234), "R4 phase frame",
            cap, exp_frame(1'b0, 5'd9, 5'd4, 16'h1234));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        vectors = vectors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // main sequence
    initial begin
        logic [DW-1:0] rv;
        bit moved;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        csr_read(2'd3, rv); chk(rv == 0, "R1 control", rv, 0);
        csr_read(2'd2, rv); chk(rv == 0, "R1 read data", rv, 0);
        csr_read(2'd0, rv); chk(rv == 0, "R1 target", rv, 0);
        csr_read(2'd1, rv); chk(rv == 0, "R1 wdata", rv, 0);
        chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 2'b00);

        // R2 go without enable
        csr_write(2'd3, 32'h1);
        csr_addr = 2'd3;
        moved = 1'b0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (csr_rdata[0] || mdc) moved = 1'b1;
            @(negedge clk);
        end
        chk(!moved, "R2 no activity", moved, 0);
        chk(k == 0, "R2 no mdc edges", k, 0);
        csr_read(2'd3, rv); chk(rv == 0, "R2 control", rv, 0);

        // R7 clock phases
        run_phase();

        // sweep every PHY address
        for (int p = 0; p < 32; p++) begin
            run_xfer(p[0], 5'(p), 5'((p * 5 + 7) % 32), 16'hB4E1 ^ 16'(p * 16'h0919), 1'b0);
        end
        // sweep every register number
        for (int r = 0; r < 32; r++) begin
            run_xfer(!r[0], 5'((r * 3 + 1) % 32), 5'(r), 16'h5A0F ^ 16'(r * 16'h1357), 1'b0);
        end
        // extremes
        run_xfer(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
        run_xfer(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0);
        run_xfer(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b0);
        run_xfer(1'b0, 5'd0, 5'd0, 16'h0000, 1'b0);
        // R9 disturbance during write and read frames
        run_xfer(1'b0, 5'd12, 5'd19, 16'hC3A5, 1'b1);
        run_xfer(1'b1, 5'd21, 5'd6, 16'h7E81, 1'b1);

        chk(contention == 0, "R5 no contention", contention, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule